// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a host read and write PHY registers over a two-wire management bus: a clock line (MDC) that the block drives and a bidirectional data line (MDIO). The host sees three words on a simple register port. The frame word (address 0) holds one complete management frame. The divider word (address 1) sets the MDC half-period in system clocks. The status word (address 2) gives busy in bit 0 and a sticky done flag in bit 1.

A frame starts when the host writes the frame word. If the divider is zero at that moment, the frame is held back. A later write of a non-zero divider then sends it, so the two words can be written in either order. Each frame is 32 preamble ones followed by the 32 bits of the frame word, most significant bit first. The word shifts in place while the frame runs. The read or write direction comes from one opcode bit only, so opcodes that do not follow the standard still produce frames. On a read, the block releases MDIO for the PHY, and at the end the 16 bits it sampled sit in the low half of the frame word.

The controller has five states:
- `ST_IDLE`: nothing is sent. It moves to `ST_PREAMBLE` on a launch.
- `ST_PREAMBLE`: 32 bits of ones are sent. It then moves to `ST_ADDR`.
- `ST_ADDR`: 14 bits are sent, covering the start, opcode and the two address fields. It then moves to `ST_TURN`.
- `ST_TURN`: the 2 turnaround bits. It then moves to `ST_DATA`.
- `ST_DATA`: 16 data bits. It then returns to `ST_IDLE` and sets done.

Each move happens on the MDC falling edge that ends the last bit of the segment.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset MDC is low, MDIO is released (`mdio_oe`=0), busy is 0, done is 0, and the status word reads 0.
- R2: Frame word layout, from the top bit down: bits 31:30 start, 29:28 opcode, 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data. After the preamble, the word is sent bit 31 first. Each driven bit changes only when MDC falls.
- R3: A write to address 0 while idle, with a non-zero divider, raises busy in the next cycle.
- R4: A frame-word write with a zero divider starts nothing. A later non-zero divider write (address 1, bits 7:0) then starts a frame from the stored word. A divider write with no frame held back starts nothing.
- R5: Each bit lasts 2*S system clocks: MDC is low for S clocks, then high for S clocks. S is the divider value taken at launch, so a later divider write does not change a running frame. MDC is low while idle.
- R6: Every frame begins with 32 MDC periods in which MDIO is driven to 1.
- R7: The direction comes from bit 29 alone. When bit 29 is 1, MDIO is released from frame bit 15 (the second turnaround bit) through bit 31. When bit 29 is 0, all 32 frame bits are driven. This holds for opcodes 10, 11, 01 and 00 alike.
- R8: MDIO is sampled on each MDC rising edge. After a read frame, frame-word bits 15:0 hold the 16 data-bit samples, with the first one in bit 15.
- R9: Busy is 1 for the whole 128*S clocks of a frame. When the frame ends, busy clears and done sets. Writing a 1 to status bit 1 clears done.
- R10: Frame-word writes during a frame are ignored. No new frame starts and the shifted result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Word select: 0 frame, 1 divider, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives) |
| mdio_i | input | 1 | MDIO line value |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky frame-complete flag |

## Verification
The bench targets these corner cases:
- **Zero-divider ordering.** A design that drops the held frame, or that starts one on any divider write, shows a wrong busy edge.
- **Non-standard opcodes 11 and 00.** A design that decodes both opcode bits releases or drives MDIO on the wrong bits.
- **The single-bit release at the second turnaround bit.** An off-by-one there drives against the PHY or samples late, which corrupts the returned data.
- **Frame and divider writes during a frame.** A design that reloads the word or rescales MDC mid-frame breaks the per-clock comparison of MDC, MDIO and busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W   = 32;
    localparam int PRE_BITS  = 32;
    localparam int ADDR_BITS = 14;
    localparam int TURN_BITS = 2;
    localparam int DATA_BITS = 16;
    localparam int SEG_CNT_W = $clog2(PRE_BITS + 1);
    localparam int DIR_BIT   = 29;

    localparam logic [1:0] A_FRAME = 2'd0;
    localparam logic [1:0] A_SPEED = 2'd1;
    localparam logic [1:0] A_STAT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_ADDR,
        ST_TURN,
        ST_DATA
    } mstate_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] cnt;
    logic             ph;
    logic             term;

    assign term = (cnt == half - {{(DIV_W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise_ev = run && term && !ph;
    assign fall_ev = run && term && ph;
    assign mdc     = ph;
endmodule

// File: rtl/mdio_shreg.sv
module mdio_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         capture,
    input  logic         shift,
    input  logic         mdio_in,
    output logic [W-1:0] q
);
    logic samp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            samp <= 1'b0;
        end else begin
            if (capture) begin
                samp <= mdio_in;
            end
            if (load) begin
                q <= load_val;
            end else if (shift) begin
                q <= {q[W-2:0], samp};
            end
        end
    end
endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    launch,
    input  logic    fall_ev,
    input  logic    rd_mode,
    output mstate_t state,
    output logic    busy,
    output logic    shifting,
    output logic    preamble,
    output logic    drive_en,
    output logic    frame_end
);
    mstate_t              nxt;
    logic [SEG_CNT_W-1:0] idx;
    logic [SEG_CNT_W-1:0] seg_last;
    logic                 last_bit;

    always_comb begin
        unique case (state)
            ST_PREAMBLE: seg_last = SEG_CNT_W'(PRE_BITS - 1);
            ST_ADDR:     seg_last = SEG_CNT_W'(ADDR_BITS - 1);
            ST_TURN:     seg_last = SEG_CNT_W'(TURN_BITS - 1);
            ST_DATA:     seg_last = SEG_CNT_W'(DATA_BITS - 1);
            default:     seg_last = '0;
        endcase
    end

    assign last_bit = fall_ev && (idx == seg_last);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (launch)   nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (last_bit) nxt = ST_ADDR;
            ST_ADDR:     if (last_bit) nxt = ST_TURN;
            ST_TURN:     if (last_bit) nxt = ST_DATA;
            ST_DATA:     if (last_bit) nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            if (state != nxt) begin
                idx <= '0;
            end else if (fall_ev) begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        busy      = 1'b0;
        shifting  = 1'b0;
        preamble  = 1'b0;
        drive_en  = 1'b0;
        frame_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_PREAMBLE: begin
                busy     = 1'b1;
                preamble = 1'b1;
                drive_en = 1'b1;
            end
            ST_ADDR: begin
                busy     = 1'b1;
                shifting = 1'b1;
                drive_en = 1'b1;
            end
            ST_TURN: begin
                busy     = 1'b1;
                shifting = 1'b1;
                drive_en = !(rd_mode && idx == SEG_CNT_W'(TURN_BITS - 1));
            end
            ST_DATA: begin
                busy      = 1'b1;
                shifting  = 1'b1;
                drive_en  = !rd_mode;
                frame_end = last_bit;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done
);
    logic [DIV_W-1:0]   spd_q;
    logic [DIV_W-1:0]   hold_div;
    logic               pend_q;
    logic               done_q;
    logic               rd_mode_q;
    logic [FRAME_W-1:0] frm_q;
    mstate_t            state;
    logic               shifting, preamble, frame_end;
    logic               rise_ev, fall_ev;
    logic               idle, wr_frame, wr_speed, go_frame, go_speed, launch;

    assign idle     = (state == ST_IDLE);
    assign wr_frame = host_we && host_addr == A_FRAME && idle;
    assign wr_speed = host_we && host_addr == A_SPEED;
    assign go_frame = wr_frame && spd_q != '0;
    assign go_speed = wr_speed && idle && pend_q && host_wdata[DIV_W-1:0] != '0;
    assign launch   = go_frame || go_speed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q     <= '0;
            hold_div  <= '0;
            pend_q    <= 1'b0;
            done_q    <= 1'b0;
            rd_mode_q <= 1'b0;
        end else begin
            if (wr_speed) begin
                spd_q <= host_wdata[DIV_W-1:0];
            end
            if (launch) begin
                hold_div  <= go_speed ? host_wdata[DIV_W-1:0] : spd_q;
                rd_mode_q <= go_speed ? frm_q[DIR_BIT] : host_wdata[DIR_BIT];
                pend_q    <= 1'b0;
            end else if (wr_frame) begin
                pend_q <= 1'b1;
            end
            if (frame_end) begin
                done_q <= 1'b1;
            end else if (host_we && host_addr == A_STAT && host_wdata[1]) begin
                done_q <= 1'b0;
            end
        end
    end

    mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!idle),
        .half    (hold_div),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .fall_ev   (fall_ev),
        .rd_mode   (rd_mode_q),
        .state     (state),
        .busy      (busy),
        .shifting  (shifting),
        .preamble  (preamble),
        .drive_en  (mdio_oe),
        .frame_end (frame_end)
    );

    mdio_shreg #(.W(FRAME_W)) shreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_frame),
        .load_val (host_wdata),
        .capture  (rise_ev && shifting),
        .shift    (fall_ev && shifting),
        .mdio_in  (mdio_i),
        .q        (frm_q)
    );

    assign mdio_o = preamble | (shifting & frm_q[FRAME_W-1]);
    assign done   = done_q;

    always_comb begin
        case (host_addr)
            A_FRAME: host_rdata = frm_q;
            A_SPEED: host_rdata = {{(32-DIV_W){1'b0}}, spd_q};
            A_STAT:  host_rdata = {30'd0, done_q, busy};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic [1:0]       host_addr,
    input logic             busy,
    input logic             done,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic [DIV_W-1:0] spd_q
);
    // R3: a frame write while idle with a non-zero divider starts a frame
    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && !busy && spd_q != '0) |=> busy);

    // R4: a frame write with a zero divider is held back
    p_zero_div_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == 2'd0 && !busy && spd_q == '0) |=> !busy);

    // R5: the bus is quiet outside a frame
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R9: the end of a frame sets done
    p_done_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2: a driven bit changes only when MDC falls
    p_bit_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_o))
            |-> $fell(mdc));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.DIV_W(DIV_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .spd_q     (spd_q)
);

// File: tb/mdio_frame_ctrl_tb.sv
module mdio_frame_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i, busy, done;
    logic        phy_bit = 1'b1;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_bit;

    mdio_frame_ctrl #(.DIV_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .done       (done)
    );

    function automatic logic [31:0] mkf(input logic [1:0] op, input logic [4:0] pa,
                                        input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    function automatic logic [15:0] phy_fn(input logic [4:0] pa, input logic [4:0] ra);
        return {3'b101, pa, ra, 3'b011};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_active, m_pending, m_done, m_rd, checking;
    int          m_k, m_S, m_speed;
    logic [31:0] m_frame;
    logic [15:0] m_phyval;

    task automatic m_launch(input int s);
        m_active  = 1'b1;
        m_k       = 0;
        m_S       = s;
        m_rd      = m_frame[29];
        m_pending = 1'b0;
        m_phyval  = phy_fn(m_frame[27:23], m_frame[22:18]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_pending = 0; m_done = 0; m_rd = 0;
            m_k = 0; m_S = 1; m_speed = 0; m_frame = '0;
        end else begin
            bit was, fin;
            was = m_active;
            fin = 0;
            if (m_active) begin
                m_k++;
                if (m_k == 128 * m_S) begin
                    m_active = 0;
                    fin = 1;
                end
            end
            if (host_we) begin
                case (host_addr)
                    2'd0: if (!was) begin
                        m_frame = host_wdata;
                        if (m_speed != 0) m_launch(m_speed);
                        else m_pending = 1;
                    end
                    2'd1: begin
                        m_speed = int'(host_wdata[7:0]);
                        if (!was && m_pending && m_speed != 0) m_launch(m_speed);
                    end
                    2'd2: if (host_wdata[1]) m_done = 0;
                    default: ;
                endcase
            end
            if (fin) m_done = 1;
        end
    end

    // per-clock comparison and PHY responder
    always @(negedge clk) begin
        if (rst_n && checking) begin
            int  bitn, fb;
            bit  e_mdc, e_oe, e_o;
            e_mdc = 0; e_oe = 0; e_o = 0; fb = -1; bitn = 0;
            if (m_active) begin
                bitn  = m_k / (2 * m_S);
                e_mdc = (m_k % (2 * m_S)) >= m_S;
                if (bitn < 32) begin
                    e_oe = 1; e_o = 1;
                end else begin
                    fb   = bitn - 32;
                    e_oe = !(m_rd && fb >= 15);
                    e_o  = m_frame[31 - fb];
                end
            end
            chk(busy == m_active, "R9", "busy", busy, m_active);
            chk(done == m_done, "R9", "done", done, m_done);
            chk(mdc == e_mdc, "R5", "mdc", mdc, e_mdc);
            chk(mdio_oe == e_oe, "R7", "mdio_oe", mdio_oe, e_oe);
            if (e_oe && m_active)
                chk(mdio_o == e_o, (fb < 0) ? "R6" : "R2", "mdio_o", mdio_o, e_o);
            if (m_active && m_rd && fb == 15) phy_bit = 1'b0;
            else if (m_active && m_rd && fb >= 16) phy_bit = m_phyval[31 - fb];
            else phy_bit = 1'b1;
        end
    end

    // ---------------- host tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic read_frame_check(input string tag, input logic [4:0] pa, input logic [4:0] ra);
        logic [31:0] v;
        wait_idle();
        rd(2'd0, v);
        chk(v[15:0] == phy_fn(pa, ra), tag, "read data low half", v[15:0], phy_fn(pa, ra));
    endtask

    initial begin
        logic [31:0] v;
        checking = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(mdc == 0, "R1", "mdc", mdc, 0);
        chk(mdio_oe == 0, "R1", "mdio_oe", mdio_oe, 0);
        rd(2'd2, v);
        chk(v == 0, "R1", "status word", v, 0);
        checking = 1;

        // R4: divider write with nothing held back starts nothing
        wr(2'd1, 32'd2);
        repeat (3) @(negedge clk);
        chk(busy == 0, "R4", "busy after lone divider write", busy, 0);

        // R3 / R2: compliant write frame
        wr(2'd0, mkf(2'b01, 5'd5, 5'd3, 16'hBEEF));
        chk(busy == 1, "R3", "busy after launch", busy, 1);
        wait_idle();
        rd(2'd2, v);
        chk(v[1:0] == 2'b10, "R9", "status after frame", v[1:0], 2);
        wr(2'd2, 32'h2);
        chk(done == 0, "R9", "done after clear", done, 0);

        // R8: compliant read frame, slower MDC
        wr(2'd1, 32'd3);
        wr(2'd0, mkf(2'b10, 5'h11, 5'h1E, 16'h0000));
        read_frame_check("R8", 5'h11, 5'h1E);

        // R7: opcode 11 behaves as a read
        wr(2'd1, 32'd1);
        wr(2'd0, mkf(2'b11, 5'h0A, 5'h07, 16'h1234));
        read_frame_check("R7", 5'h0A, 5'h07);
        // R7: opcode 00 behaves as a write (per-clock oe compare)
        wr(2'd0, mkf(2'b00, 5'h1F, 5'h00, 16'hA5A5));
        chk(busy == 1, "R7", "busy opcode 00", busy, 1);
        wait_idle();

        // R4: zero divider holds the frame
        wr(2'd1, 32'd0);
        wr(2'd0, mkf(2'b10, 5'h03, 5'h19, 16'h0));
        repeat (40) @(negedge clk);
        chk(busy == 0, "R4", "busy with zero divider", busy, 0);
        chk(mdc == 0, "R4", "mdc with zero divider", mdc, 0);
        wr(2'd1, 32'd2);
        chk(busy == 1, "R4", "busy after divider release", busy, 1);
        read_frame_check("R4", 5'h03, 5'h19);

        // R10 / R5: writes during a frame
        wr(2'd0, mkf(2'b10, 5'h08, 5'h0C, 16'h0));
        repeat (20) @(negedge clk);
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'd5);
        read_frame_check("R10", 5'h08, 5'h0C);
        repeat (12) @(negedge clk);
        chk(busy == 0, "R10", "no second frame", busy, 0);

        // R5: the new divider applies to the next frame
        wr(2'd0, mkf(2'b01, 5'h01, 5'h02, 16'h00FF));
        wait_idle();
        repeat (2) @(negedge clk);

        checking = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule